// File: doc/BRIEF.md
# Extended Capability Chain Walker

This block walks a singly linked chain of 32-bit capability headers held in the upper part of a 4 KB configuration RAM. Every header carries an identifier in its low half, a small version number above that, and the offset of the next header in its top twelve bits. A zero pointer closes the chain, and the chain always begins at offset 0x100.

Two commands are supported. A find looks for the first header whose identifier equals the requested one. It reports the offset of the match together with the offset of the entry that links to it. An append places a new header at a caller-chosen offset. At 0x100 it writes the header straight away. At any other offset it first walks to the current tail, using a search key wider than the identifier field so that no header can match. It then rewrites only the tail's pointer field and writes the new header with a zero pointer. The RAM port is synchronous with one cycle of read latency, and each visited header costs two cycles.

Top module: `capchain_walker`

## Requirements
- R1: A header is split as identifier = bits 15:0, version = bits 19:16, next offset = bits 31:20. A find matches on the identifier field alone, whatever the version bits hold.
- R2: Every walk starts at offset 0x100. If the header there is all zero, the chain is empty, and a find ends with found low, result_off 0 and prev_off 0.
- R3: The walk follows next pointers until a match or a zero pointer. A find that reaches a zero pointer ends with found low, result_off 0 and prev_off equal to the tail offset.
- R4: A find hit ends with found high, result_off equal to the matching offset, and prev_off equal to the offset that linked to it (0 when the match is at 0x100).
- R5: A next pointer below 0x100, above 0xFF8, or not a multiple of 4 ends the walk with error high and found low.
- R6: After MAX_HOPS headers have been visited without a match or a zero pointer, the walk ends with error high (guard against looped chains).
- R7: An append at offset 0x100 performs no RAM read and exactly one write, storing {next = 0, version, identifier} at 0x100. It ends with result_off 0x100 and prev_off 0.
- R8: An append at another offset walks to the tail (0x100 when the chain is empty). It rewrites the tail as {new offset, old tail bits 19:0}, then writes {next = 0, version, identifier} at the new offset. It ends with error low, result_off equal to the new offset and prev_off equal to the tail.
- R9: An append whose offset is below 0x100, above 0xFF8, or not a multiple of 4 ends with error high and performs no RAM access.
- R10: done is high for exactly one cycle per command. A start while busy is ignored. found, error, result_off and prev_off hold their values until the next command finishes.
- R11: After reset, busy, done, mem_en and mem_we are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe, accepted while busy is low |
| op | input | 1 | 0 = find, 1 = append |
| cap_id | input | 16 | Identifier to find or to write |
| cap_ver | input | 4 | Version written by an append |
| cap_off | input | 12 | Byte offset of the header an append creates |
| busy | output | 1 | Command in progress (includes the done cycle) |
| mem_en | output | 1 | RAM access enable |
| mem_we | output | 1 | RAM write enable |
| mem_addr | output | 10 | RAM word address (byte offset bits 11:2) |
| mem_wdata | output | 32 | RAM write data |
| mem_rdata | input | 32 | RAM read data, valid the cycle after a read |
| done | output | 1 | One-cycle completion pulse |
| found | output | 1 | Find matched |
| error | output | 1 | Bad pointer, bad offset or hop limit |
| result_off | output | 12 | Matched offset (find) or new header offset (append) |
| prev_off | output | 12 | Previous entry (find hit), tail (find miss, append) |

## Verification
On every cycle the assertions check the following properties. done lasts one cycle. A hit never comes with an error and points to an aligned offset inside the chain range. Writes happen only under an append. The header written at the new offset carries a zero pointer and the requested identifier. Results stay put while the block is idle. RAM accesses never fall below 0x100. Only the bench scenarios, checked against a reference walk over the bench's own RAM copy, can show the remaining behaviours. These are the right previous and tail offsets, the tail patch that keeps bits 19:0, the error ending on looped or out-of-range chains, and the absence of any access on a rejected append.

// File: rtl/chain_pkg.sv
package chain_pkg;

   localparam logic OP_FIND   = 1'b0;
   localparam logic OP_APPEND = 1'b1;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_READ,
      ST_EVAL,
      ST_PATCH,
      ST_WRNEW,
      ST_FIN
   } walk_st_t;

endpackage

// File: rtl/chain_off_check.sv
// Flags an offset that may not hold a header: outside [BASE_OFF, top-8]
// or, when STRICT_ALIGN is set, not on a 4-byte boundary.
module chain_off_check #(
   parameter int OFF_W        = 12,
   parameter int BASE_OFF     = 'h100,
   parameter bit STRICT_ALIGN = 1'b1
) (
   input  logic [OFF_W-1:0] off,
   output logic             bad
);
   localparam int               LAST_OFF = (1 << OFF_W) - 8;
   localparam logic [OFF_W-1:0] LO_L     = OFF_W'(BASE_OFF);
   localparam logic [OFF_W-1:0] HI_L     = OFF_W'(LAST_OFF);

   logic out_rng;
   logic misal;

   assign out_rng = (off < LO_L) || (off > HI_L);

   generate
      if (STRICT_ALIGN) begin : g_align
         assign misal = |off[1:0];
      end else begin : g_noalign
         assign misal = 1'b0;
      end
   endgenerate

   assign bad = out_rng || misal;
endmodule

// File: rtl/chain_hdr_split.sv
// Splits one header word and compares it with the search key.
// The key is one bit wider than the identifier; a set top bit never matches.
module chain_hdr_split #(
   parameter int ID_W  = 16,
   parameter int VER_W = 4,
   parameter int OFF_W = 12,
   localparam int DATA_W = ID_W + VER_W + OFF_W
) (
   input  logic [DATA_W-1:0] hdr,
   input  logic [ID_W:0]     key,
   output logic              id_hit,
   output logic [OFF_W-1:0]  nxt,
   output logic              nxt_zero,
   output logic              hdr_zero
);
   assign id_hit   = (key == {1'b0, hdr[ID_W-1:0]});
   assign nxt      = hdr[DATA_W-1 -: OFF_W];
   assign nxt_zero = (nxt == '0);
   assign hdr_zero = (hdr == '0);
endmodule

// File: rtl/chain_hop_guard.sv
// Counts followed pointers; last is raised when one more hop would reach MAX_HOPS.
module chain_hop_guard #(
   parameter int MAX_HOPS = 1024,
   localparam int CW = $clog2(MAX_HOPS + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic last
);
   localparam logic [CW-1:0] LIM = CW'(MAX_HOPS - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr) begin
         cnt_q <= '0;
      end else if (inc) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign last = (cnt_q == LIM);
endmodule

// File: rtl/capchain_walker.sv
module capchain_walker
   import chain_pkg::*;
#(
   parameter int ID_W         = 16,
   parameter int VER_W        = 4,
   parameter int OFF_W        = 12,
   parameter int BASE_OFF     = 'h100,
   parameter int MAX_HOPS     = 1024,
   parameter bit STRICT_ALIGN = 1'b1,
   localparam int DATA_W = ID_W + VER_W + OFF_W,
   localparam int AW     = OFF_W - 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              op,
   input  logic [ID_W-1:0]   cap_id,
   input  logic [VER_W-1:0]  cap_ver,
   input  logic [OFF_W-1:0]  cap_off,
   output logic              busy,
   output logic              mem_en,
   output logic              mem_we,
   output logic [AW-1:0]     mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic              found,
   output logic              error,
   output logic [OFF_W-1:0]  result_off,
   output logic [OFF_W-1:0]  prev_off
);
   localparam logic [OFF_W-1:0] BASE_L = OFF_W'(BASE_OFF);
   localparam int               TAILW  = ID_W + VER_W;

   generate
      if (DATA_W != 32) begin : g_bad_width
         $error("header fields must add up to a 32-bit word");
      end
      if (BASE_OFF % 4 != 0) begin : g_bad_base
         $error("chain base offset must be word aligned");
      end
      if (MAX_HOPS < 2) begin : g_bad_hops
         $error("hop limit must be at least 2");
      end
   endgenerate

   walk_st_t            st_q;
   logic                op_q;
   logic [ID_W-1:0]     id_q;
   logic [VER_W-1:0]    ver_q;
   logic [OFF_W-1:0]    off_q, cur_q, prev_q, tail_q;
   logic [DATA_W-1:0]   hdr_q;
   logic                found_q, err_q;
   logic [OFF_W-1:0]    res_q, prv_q;

   logic [ID_W:0]       key;
   logic                id_hit, nxt_zero, hdr_zero, nxt_bad, cmd_bad, hop_last;
   logic [OFF_W-1:0]    nxt;
   logic                ev_empty, ev_hit, ev_tail, ev_err, ev_follow;

   assign key = (op_q == OP_APPEND) ? {1'b1, {ID_W{1'b0}}} : {1'b0, id_q};

   chain_hdr_split #(.ID_W(ID_W), .VER_W(VER_W), .OFF_W(OFF_W)) u_split (
      .hdr      (mem_rdata),
      .key      (key),
      .id_hit   (id_hit),
      .nxt      (nxt),
      .nxt_zero (nxt_zero),
      .hdr_zero (hdr_zero)
   );

   chain_off_check #(.OFF_W(OFF_W), .BASE_OFF(BASE_OFF), .STRICT_ALIGN(STRICT_ALIGN)) u_nxt_chk (
      .off (nxt),
      .bad (nxt_bad)
   );

   chain_off_check #(.OFF_W(OFF_W), .BASE_OFF(BASE_OFF), .STRICT_ALIGN(STRICT_ALIGN)) u_cmd_chk (
      .off (cap_off),
      .bad (cmd_bad)
   );

   chain_hop_guard #(.MAX_HOPS(MAX_HOPS)) u_hops (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (st_q == ST_IDLE),
      .inc   (ev_follow),
      .last  (hop_last)
   );

   // Decisions taken while a header is on the read port, in priority order.
   always_comb begin
      ev_empty  = 1'b0;
      ev_hit    = 1'b0;
      ev_tail   = 1'b0;
      ev_err    = 1'b0;
      ev_follow = 1'b0;
      if (st_q == ST_EVAL) begin
         if (cur_q == BASE_L && hdr_zero) begin
            ev_empty = 1'b1;
         end else if (id_hit) begin
            ev_hit = 1'b1;
         end else if (nxt_zero) begin
            ev_tail = 1'b1;
         end else if (hop_last || nxt_bad) begin
            ev_err = 1'b1;
         end else begin
            ev_follow = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q    <= ST_IDLE;
         op_q    <= OP_FIND;
         id_q    <= '0;
         ver_q   <= '0;
         off_q   <= '0;
         cur_q   <= '0;
         prev_q  <= '0;
         tail_q  <= '0;
         hdr_q   <= '0;
         found_q <= 1'b0;
         err_q   <= 1'b0;
         res_q   <= '0;
         prv_q   <= '0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               if (start) begin
                  op_q   <= op;
                  id_q   <= cap_id;
                  ver_q  <= cap_ver;
                  off_q  <= cap_off;
                  cur_q  <= BASE_L;
                  prev_q <= '0;
                  if (op == OP_APPEND && cap_off == BASE_L) begin
                     tail_q <= '0;
                     st_q   <= ST_WRNEW;
                  end else if (op == OP_APPEND && cmd_bad) begin
                     found_q <= 1'b0;
                     err_q   <= 1'b1;
                     res_q   <= '0;
                     prv_q   <= '0;
                     st_q    <= ST_FIN;
                  end else begin
                     st_q <= ST_READ;
                  end
               end
            end
            ST_READ: st_q <= ST_EVAL;
            ST_EVAL: begin
               if (ev_empty || ev_tail) begin
                  if (op_q == OP_APPEND) begin
                     tail_q <= cur_q;
                     hdr_q  <= mem_rdata;
                     st_q   <= ST_PATCH;
                  end else begin
                     found_q <= 1'b0;
                     err_q   <= 1'b0;
                     res_q   <= '0;
                     prv_q   <= ev_empty ? '0 : cur_q;
                     st_q    <= ST_FIN;
                  end
               end else if (ev_hit) begin
                  found_q <= 1'b1;
                  err_q   <= 1'b0;
                  res_q   <= cur_q;
                  prv_q   <= prev_q;
                  st_q    <= ST_FIN;
               end else if (ev_err) begin
                  found_q <= 1'b0;
                  err_q   <= 1'b1;
                  res_q   <= '0;
                  prv_q   <= cur_q;
                  st_q    <= ST_FIN;
               end else begin
                  prev_q <= cur_q;
                  cur_q  <= nxt;
                  st_q   <= ST_READ;
               end
            end
            ST_PATCH: st_q <= ST_WRNEW;
            ST_WRNEW: begin
               found_q <= 1'b0;
               err_q   <= 1'b0;
               res_q   <= off_q;
               prv_q   <= tail_q;
               st_q    <= ST_FIN;
            end
            ST_FIN:  st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   always_comb begin
      mem_en    = 1'b0;
      mem_we    = 1'b0;
      mem_addr  = cur_q[OFF_W-1:2];
      mem_wdata = '0;
      unique case (st_q)
         ST_READ: begin
            mem_en = 1'b1;
         end
         ST_PATCH: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = tail_q[OFF_W-1:2];
            mem_wdata = {off_q, hdr_q[TAILW-1:0]};
         end
         ST_WRNEW: begin
            mem_en    = 1'b1;
            mem_we    = 1'b1;
            mem_addr  = off_q[OFF_W-1:2];
            mem_wdata = {{OFF_W{1'b0}}, ver_q, id_q};
         end
         default: ;
      endcase
   end

   assign busy       = (st_q != ST_IDLE);
   assign done       = (st_q == ST_FIN);
   assign found      = found_q;
   assign error      = err_q;
   assign result_off = res_q;
   assign prev_off   = prv_q;

endmodule

// File: rtl/capchain_walker_chk.sv
module capchain_walker_chk #(
   parameter int ID_W     = 16,
   parameter int VER_W    = 4,
   parameter int OFF_W    = 12,
   parameter int BASE_OFF = 'h100,
   localparam int DATA_W = ID_W + VER_W + OFF_W,
   localparam int AW     = OFF_W - 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              op,
   input logic [ID_W-1:0]   cap_id,
   input logic [OFF_W-1:0]  cap_off,
   input logic              busy,
   input logic              done,
   input logic              found,
   input logic              error,
   input logic [OFF_W-1:0]  result_off,
   input logic              mem_en,
   input logic              mem_we,
   input logic [AW-1:0]     mem_addr,
   input logic [DATA_W-1:0] mem_wdata
);
   localparam logic [OFF_W-1:0] BASE_L = OFF_W'(BASE_OFF);
   localparam logic [AW-1:0]    BASE_W = AW'(BASE_OFF / 4);

   logic              op_c;
   logic [ID_W-1:0]   id_c;
   logic [OFF_W-1:0]  off_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_c  <= 1'b0;
         id_c  <= '0;
         off_c <= '0;
      end else if (start && !busy) begin
         op_c  <= op;
         id_c  <= cap_id;
         off_c <= cap_off;
      end
   end

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R10

   AST_IDLE_HOLDS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !start) |=> $stable(result_off) && $stable(found) && $stable(error)); // R10

   AST_HIT_IN_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (done && found) |-> (!error && result_off >= BASE_L && result_off[1:0] == 2'b00)); // R4

   AST_WRITE_ONLY_APPEND: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |-> op_c); // R7

   AST_NEW_HDR_TERMINATED: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && mem_addr == off_c[OFF_W-1:2]) |->
         (mem_wdata[DATA_W-1 -: OFF_W] == '0 && mem_wdata[ID_W-1:0] == id_c)); // R8

   AST_ACCESS_ABOVE_BASE: assert property (@(posedge clk) disable iff (!rst_n)
      mem_en |-> (mem_addr >= BASE_W)); // R5

endmodule

bind capchain_walker capchain_walker_chk #(
   .ID_W(ID_W), .VER_W(VER_W), .OFF_W(OFF_W), .BASE_OFF(BASE_OFF)
) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cap_id(cap_id),
   .cap_off(cap_off), .busy(busy), .done(done), .found(found), .error(error),
   .result_off(result_off), .mem_en(mem_en), .mem_we(mem_we),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata)
);

// File: tb/capchain_walker_tb.sv
module capchain_walker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        op = 1'b0;
   logic [15:0] cap_id = '0;
   logic [3:0]  cap_ver = '0;
   logic [11:0] cap_off = '0;
   logic        busy, mem_en, mem_we, done, found, error;
   logic [9:0]  mem_addr;
   logic [31:0] mem_wdata;
   logic [31:0] mem_rdata = '0;
   logic [11:0] result_off, prev_off;

   logic [31:0] ram [0:1023];
   int rd_cnt = 0;
   int wr_cnt = 0;
   int compared = 0;
   int mismatched = 0;
   bit finished = 0;

   logic [11:0] lst_off [0:7];
   logic [15:0] lst_id  [0:7];

   always #5 clk = ~clk;

   capchain_walker u_dut (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op), .cap_id(cap_id),
      .cap_ver(cap_ver), .cap_off(cap_off), .busy(busy), .mem_en(mem_en),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .done(done), .found(found), .error(error),
      .result_off(result_off), .prev_off(prev_off)
   );

   always @(posedge clk) begin
      if (mem_en) begin
         if (mem_we) begin
            ram[mem_addr] <= mem_wdata;
            wr_cnt <= wr_cnt + 1;
         end else begin
            mem_rdata <= ram[mem_addr];
            rd_cnt <= rd_cnt + 1;
         end
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
   end

   // Reference walk over the bench RAM copy.
   function automatic void ref_walk(input logic [16:0] key, output bit f, output bit e,
                                    output logic [11:0] res, output logic [11:0] prv);
      logic [11:0] cur = 12'h100;
      logic [11:0] prv_l = 12'h000;
      logic [31:0] h;
      logic [11:0] nx;
      int hops = 0;
      f = 0; e = 0; res = '0; prv = '0;
      for (int k = 0; k < 4096; k++) begin
         h = ram[cur[11:2]];
         if (cur == 12'h100 && h == 32'h0) return;
         if (key == {1'b0, h[15:0]}) begin
            f = 1; res = cur; prv = prv_l; return;
         end
         nx = h[31:20];
         if (nx == 12'h000) begin
            prv = cur; return;
         end
         hops++;
         if (hops >= 1024 || nx < 12'h100 || nx > 12'hFF8 || nx[1:0] != 2'b00) begin
            e = 1; prv = cur; return;
         end
         prv_l = cur;
         cur = nx;
      end
      e = 1;
   endfunction

   task automatic clear_ram();
      for (int i = 0; i < 1024; i++) ram[i] = 32'h0;
   endtask

   task automatic build_list(input int n);
      clear_ram();
      for (int i = 0; i < n; i++) begin
         lst_off[i] = (i == 0) ? 12'h100 : 12'(12'h100 + (i * 8 + $urandom_range(0, 7)) * 12'h40);
         lst_id[i]  = {4'(i), 12'($urandom)};
      end
      for (int i = 0; i < n; i++)
         ram[lst_off[i][11:2]] = {(i == n - 1) ? 12'h000 : lst_off[i + 1], 4'($urandom), lst_id[i]};
   endtask

   task automatic run_cmd(input bit o, input logic [15:0] id, input logic [3:0] v, input logic [11:0] off);
      int w = 0;
      @(negedge clk);
      start = 1'b1; op = o; cap_id = id; cap_ver = v; cap_off = off;
      @(negedge clk);
      start = 1'b0;
      while (!done && w < 5000) begin
         @(negedge clk);
         w++;
      end
      chk("R10 done seen", {31'h0, done}, 32'h1);
   endtask

   task automatic check_find(input string tag, input logic [15:0] id);
      bit f, e;
      logic [11:0] r, p;
      ref_walk({1'b0, id}, f, e, r, p);
      run_cmd(1'b0, id, 4'h0, 12'h000);
      chk({tag, " found"}, {31'h0, found}, {31'h0, f});
      chk({tag, " error"}, {31'h0, error}, {31'h0, e});
      if (!e) begin
         chk({tag, " result"}, {20'h0, result_off}, {20'h0, r});
         chk({tag, " prev"}, {20'h0, prev_off}, {20'h0, p});
      end
   endtask

   task automatic check_append(input string tag, input logic [15:0] id, input logic [3:0] v,
                               input logic [11:0] noff);
      bit f, e;
      logic [11:0] r, p, tail;
      logic [31:0] old;
      int w0;
      ref_walk(17'h10000, f, e, r, p);
      tail = (ram[12'h100 >> 2] == 32'h0) ? 12'h100 : p;
      old = ram[tail[11:2]];
      w0 = wr_cnt;
      run_cmd(1'b1, id, v, noff);
      chk({tag, " R8 error"}, {31'h0, error}, 32'h0);
      chk({tag, " R8 result"}, {20'h0, result_off}, {20'h0, noff});
      chk({tag, " R8 prev=tail"}, {20'h0, prev_off}, {20'h0, tail});
      chk({tag, " R8 tail patched"}, ram[tail[11:2]], {noff, old[19:0]});
      chk({tag, " R8 new header"}, ram[noff[11:2]], {12'h000, v, id});
      chk({tag, " R8 two writes"}, wr_cnt - w0, 2);
   endtask

   initial begin
      int r0, w0;
      logic [11:0] hold;
      void'($urandom(32'h00C0FFEE));
      clear_ram();
      repeat (3) @(negedge clk);
      // R11: quiet after reset
      chk("R11 busy", {31'h0, busy}, 0);
      chk("R11 done", {31'h0, done}, 0);
      chk("R11 mem_en", {31'h0, mem_en}, 0);
      chk("R11 mem_we", {31'h0, mem_we}, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R2: empty chain
      run_cmd(1'b0, 16'h0000, 4'h0, 12'h000);
      chk("R2 found", {31'h0, found}, 0);
      chk("R2 result", {20'h0, result_off}, 0);
      chk("R2 prev", {20'h0, prev_off}, 0);

      // R1/R3/R4: directed three-entry chain, versions nonzero
      clear_ram();
      ram[12'h100 >> 2] = {12'h240, 4'hA, 16'h0010};
      ram[12'h240 >> 2] = {12'h180, 4'h5, 16'h0001};
      ram[12'h180 >> 2] = {12'h000, 4'hF, 16'h00A5};
      run_cmd(1'b0, 16'h0010, 4'h0, 12'h000);
      chk("R4 first hit", {20'h0, result_off}, 32'h100);
      chk("R4 first prev", {20'h0, prev_off}, 0);
      run_cmd(1'b0, 16'h0001, 4'h0, 12'h000);
      chk("R1 id-only match", {31'h0, found}, 1);
      chk("R4 mid prev", {20'h0, prev_off}, 32'h100);
      run_cmd(1'b0, 16'h00A5, 4'h0, 12'h000);
      chk("R4 last hit", {20'h0, result_off}, 32'h180);
      chk("R4 last prev", {20'h0, prev_off}, 32'h240);
      run_cmd(1'b0, 16'h0A50, 4'h0, 12'h000);
      chk("R3 miss found", {31'h0, found}, 0);
      chk("R3 miss tail", {20'h0, prev_off}, 32'h180);

      // R5: bad pointers
      ram[12'h180 >> 2] = {12'h0F0, 4'h0, 16'h00A5};
      check_find("R5 low ptr", 16'h7777);
      ram[12'h180 >> 2] = {12'hFFC, 4'h0, 16'h00A5};
      check_find("R5 high ptr", 16'h7777);
      ram[12'h180 >> 2] = {12'h202, 4'h0, 16'h00A5};
      check_find("R5 misaligned ptr", 16'h7777);
      chk("R5 flagged", {31'h0, error}, 1);

      // R6: looped chain
      clear_ram();
      ram[12'h100 >> 2] = {12'h200, 4'h0, 16'h0001};
      ram[12'h200 >> 2] = {12'h100, 4'h0, 16'h0002};
      check_find("R6 loop", 16'h0003);
      chk("R6 loop error", {31'h0, error}, 1);

      // R7: direct append at base
      clear_ram();
      r0 = rd_cnt; w0 = wr_cnt;
      run_cmd(1'b1, 16'hBEEF, 4'h3, 12'h100);
      chk("R7 header", ram[12'h100 >> 2], {12'h000, 4'h3, 16'hBEEF});
      chk("R7 no reads", rd_cnt - r0, 0);
      chk("R7 one write", wr_cnt - w0, 1);
      chk("R7 result", {20'h0, result_off}, 32'h100);
      chk("R7 prev", {20'h0, prev_off}, 0);

      // R8: append onto one-entry chain, and onto empty chain elsewhere
      check_append("single", 16'h1234, 4'h2, 12'h300);
      clear_ram();
      check_append("empty", 16'h4321, 4'h1, 12'h400);

      // R9: rejected append offsets
      build_list(3);
      foreach (lst_off[i]) if (i == 0) ;
      r0 = rd_cnt; w0 = wr_cnt;
      run_cmd(1'b1, 16'h1111, 4'h1, 12'h0FC);
      chk("R9 low error", {31'h0, error}, 1);
      run_cmd(1'b1, 16'h1111, 4'h1, 12'hFFC);
      chk("R9 high error", {31'h0, error}, 1);
      run_cmd(1'b1, 16'h1111, 4'h1, 12'h302);
      chk("R9 misaligned error", {31'h0, error}, 1);
      chk("R9 no writes", wr_cnt - w0, 0);
      chk("R9 no reads", rd_cnt - r0, 0);

      // R10: start while busy ignored, done pulse, outputs held
      build_list(6);
      @(negedge clk);
      start = 1'b1; op = 1'b0; cap_id = lst_id[5];
      @(negedge clk);
      start = 1'b0;
      @(negedge clk);
      start = 1'b1; cap_id = lst_id[0];
      @(negedge clk);
      start = 1'b0;
      while (!done) @(negedge clk);
      chk("R10 busy start ignored", {20'h0, result_off}, {20'h0, lst_off[5]});
      hold = result_off;
      @(negedge clk);
      chk("R10 done one cycle", {31'h0, done}, 0);
      repeat (4) @(negedge clk);
      chk("R10 result held", {20'h0, result_off}, {20'h0, hold});

      // Random mix: R1 R3 R4 R8
      for (int it = 0; it < 40; it++) begin
         int n;
         n = $urandom_range(1, 6);
         build_list(n);
         if ($urandom_range(0, 1) == 1)
            check_find("R4 rnd hit", lst_id[$urandom_range(0, n - 1)]);
         else
            check_find("R3 rnd any", 16'($urandom));
         check_append("rnd", 16'($urandom), 4'($urandom), 12'(12'hF00 + 4 * $urandom_range(0, 62)));
      end

      summary();
   end
endmodule